// File: doc/BRIEF.md
# SPI Master on a Single Clock with Enable-Driven Bit Timing

This block is a serial peripheral interface master whose every register sits on one fast system clock. The serial clock is never a clock net. A divider raises a one-cycle enable at each half period of the serial clock, and the serial clock pin, the outgoing data bit and the incoming sample all advance on that enable. The block supports all four combinations of idle polarity (`cpol`) and sampling phase (`cpha`). Words are sent most significant bit first.

A user side loads a word with a one-cycle write strobe and gets each received word back with a one-cycle valid strobe. A request strobe `tx_req` fires a fixed number of system cycles before the current word ends. If the next word is written by the final cycle of the current word, the select line stays low and the next word follows with no gap. If no word arrives in time, the select line rises together with the last serial clock edge.

Top module: `spi_ce_master`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the next cycle shows `ss_n`=1, `busy`=0, `tx_req`=0, `rx_valid`=0 and `sck` equal to `cpol`.
- R2: While no transfer is running, `sck` equals the `cpol` value of the previous cycle.
- R3: A `tx_wr` pulse while idle drives `ss_n` low and `busy` high in the next cycle, with bit WORD_W-1 of `tx_data` already on `mosi`.
- R4: During a word, `sck` toggles once every CLK_DIV system cycles. The first toggle comes CLK_DIV cycles after the word starts. There are exactly 2*WORD_W toggles per word, which returns `sck` to `cpol`.
- R5: `mosi` carries the word MSB first. With `cpha`=0 it advances after each odd-numbered toggle (counting from 0), except the last. With `cpha`=1 it advances after each even-numbered toggle except toggle 0. It never changes between toggles.
- R6: `miso` is taken at the clock edge on which `sck` makes a sampling toggle: the even-numbered toggles for `cpha`=0 and the odd-numbered ones for `cpha`=1. It is shifted in MSB first.
- R7: `rx_valid` is high for exactly one cycle, right after the last sampling toggle of a word, and `rx_data` then holds the word received.
- R8: `tx_req` is high for exactly one cycle per word, when PREFETCH system cycles of the word remain (word cycle index 2*WORD_W*CLK_DIV-PREFETCH, counted from 0).
- R9: A word written while a transfer runs, up to and including the cycle of the final toggle, is sent right after the current word. `ss_n` stays low and the first toggle of the new word again comes CLK_DIV cycles later.
- R10: If several words are written during one running word, the last one written is the one sent next.
- R11: With no word waiting at the final toggle, `ss_n` rises and `busy` falls on that same clock edge.
- R12: A reset in the middle of a word abandons it: `ss_n` goes high and `sck` returns to `cpol` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpol | input | 1 | Serial clock idle level; change only while idle |
| cpha | input | 1 | 0: sample on leading toggle, 1: sample on trailing toggle |
| tx_data | input | WORD_W | Word to send |
| tx_wr | input | 1 | One-cycle write strobe for `tx_data` |
| tx_req | output | 1 | Early request for the next word |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | A transfer is running |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data in |

## Verification
The bench runs every polarity and phase combination. It checks the word boundary where a write arrives after the request, which a design that ignored late writes would answer with a select glitch between words. It overwrites a waiting word twice within one word; a design that kept the first write would shift out stale data. A pseudo-random `miso` changes every cycle, so sampling one cycle early or late, or on the wrong toggle parity, shows up as corrupted received words. A reset in the middle of a word catches a design that left the select low or the clock off its idle level.

// File: rtl/spi_ce_pkg.sv
package spi_ce_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spi_state_e;

  // Per-cycle strobes derived from the half-period enable.
  typedef struct packed {
    logic tick;         // serial clock toggles this edge
    logic sample;       // toggle on which miso is taken
    logic change;       // toggle on which mosi advances
    logic last;         // final toggle of the word
    logic last_sample;  // sampling toggle that completes the word
  } spi_edge_t;

endpackage

// File: rtl/spi_ce_timer.sv
module spi_ce_timer
  import spi_ce_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int CLK_DIV  = 2,
  parameter int PREFETCH = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      cpha,
  output spi_edge_t ev,
  output logic      req
);

  localparam int EDGES    = 2 * WORD_W;
  localparam int EW       = $clog2(EDGES);
  localparam int DW       = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int WORD_CYC = EDGES * CLK_DIV;
  localparam int CW       = $clog2(WORD_CYC);
  localparam int REQ_AT   = WORD_CYC - PREFETCH;

  logic [DW-1:0] div_q, div_d;
  logic [EW-1:0] edge_q, edge_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          tick, last_edge, smp;

  // next-state: half-period divider, toggle index and cycle-in-word index
  always_comb begin
    tick      = run && (div_q == DW'(CLK_DIV - 1));
    last_edge = (edge_q == EW'(EDGES - 1));
    div_d     = div_q;
    edge_d    = edge_q;
    cyc_d     = cyc_q;
    if (!run) begin
      div_d  = '0;
      edge_d = '0;
      cyc_d  = '0;
    end else if (tick) begin
      div_d = '0;
      if (last_edge) begin
        edge_d = '0;
        cyc_d  = '0;
      end else begin
        edge_d = edge_q + EW'(1);
        cyc_d  = cyc_q + CW'(1);
      end
    end else begin
      div_d = div_q + DW'(1);
      cyc_d = cyc_q + CW'(1);
    end

    smp            = tick && (edge_q[0] == cpha);
    ev.tick        = tick;
    ev.last        = tick && last_edge;
    ev.sample      = smp;
    ev.change      = tick && (edge_q[0] != cpha) && (edge_q != '0) && !last_edge;
    ev.last_sample = smp && (edge_q == (cpha ? EW'(EDGES - 1) : EW'(EDGES - 2)));
    req            = run && (cyc_q == CW'(REQ_AT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      edge_q <= '0;
      cyc_q  <= '0;
    end else begin
      div_q  <= div_d;
      edge_q <= edge_d;
      cyc_q  <= cyc_d;
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R8

endmodule

// File: rtl/spi_ce_txpath.sv
module spi_ce_txpath
  import spi_ce_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              running,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_data,
  input  spi_edge_t         ev,
  output logic              mosi,
  output logic              cont
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] pdata_q, pdata_d;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] nxt_word;

  always_comb begin
    cont     = ev.last && (wr || pend_q);
    nxt_word = wr ? wr_data : pdata_q;

    sh_d = sh_q;
    if (start)          sh_d = wr_data;
    else if (cont)      sh_d = nxt_word;
    else if (ev.change) sh_d = {sh_q[WORD_W-2:0], 1'b0};

    pend_d  = pend_q;
    pdata_d = pdata_q;
    if (cont) begin
      pend_d = 1'b0;
    end else if (running && wr) begin
      pend_d  = 1'b1;
      pdata_d = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      pdata_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      pdata_q <= pdata_d;
      pend_q  <= pend_d;
    end
  end

  // shift register and serial pin share one register stage with sck
  assign mosi = sh_q[WORD_W-1];

  AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.last && pend_q) |=> !pend_q); // R10

endmodule

// File: rtl/spi_ce_rxpath.sv
module spi_ce_rxpath
  import spi_ce_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miso,
  input  spi_edge_t         ev,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [WORD_W-1:0] rsh_q, rsh_d;
  logic [WORD_W-1:0] rdat_q, rdat_d;
  logic              rval_q, rval_d;

  // miso enters the shifter unregistered, on the sampling enable
  always_comb begin
    rsh_d  = ev.sample ? {rsh_q[WORD_W-2:0], miso} : rsh_q;
    rdat_d = ev.last_sample ? {rsh_q[WORD_W-2:0], miso} : rdat_q;
    rval_d = ev.last_sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsh_q  <= '0;
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      rsh_q  <= rsh_d;
      rdat_q <= rdat_d;
      rval_q <= rval_d;
    end
  end

  assign rx_data  = rdat_q;
  assign rx_valid = rval_q;

  AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7

endmodule

// File: rtl/spi_ce_master.sv
module spi_ce_master
  import spi_ce_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int CLK_DIV  = 2,
  parameter int PREFETCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic              tx_req,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  input  logic              miso
);

  spi_state_e state_q, state_d;
  logic       sck_q, sck_d;
  logic       ss_q, ss_d;
  logic       running, start, cont;
  spi_edge_t  ev;

  assign running = (state_q == ST_RUN);
  assign start   = !running && tx_wr;

  spi_ce_timer #(
    .WORD_W  (WORD_W),
    .CLK_DIV (CLK_DIV),
    .PREFETCH(PREFETCH)
  ) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (running),
    .cpha (cpha),
    .ev   (ev),
    .req  (tx_req)
  );

  spi_ce_txpath #(
    .WORD_W(WORD_W)
  ) i_txpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .running(running),
    .wr     (tx_wr),
    .wr_data(tx_data),
    .ev     (ev),
    .mosi   (mosi),
    .cont   (cont)
  );

  spi_ce_rxpath #(
    .WORD_W(WORD_W)
  ) i_rxpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .miso    (miso),
    .ev      (ev),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  // next-state for the word sequencer and the serial clock / select pins
  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (tx_wr) state_d = ST_RUN;
    end else begin
      if (ev.last && !cont) state_d = ST_IDLE;
    end
    sck_d = !running ? cpol : (ev.tick ? ~sck_q : sck_q);
    ss_d  = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= cpol;
      ss_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      ss_q    <= ss_d;
    end
  end

  assign sck  = sck_q;
  assign ss_n = ss_q;
  assign busy = running;

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $stable(cpol)) |-> (sck == cpol)); // R2

  AST_SCK_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ev.tick) |=> $stable(sck)); // R4

  AST_MOSI_BETWEEN_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && !ev.tick) |=> $stable(mosi)); // R5

  AST_SS_HELD_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ev.last) |=> !ss_n); // R9

endmodule

// File: tb/test_spi_ce_master.sv
`timescale 1ns/1ps
module test_spi_ce_master;

  localparam int W     = 8;
  localparam int DIV   = 2;
  localparam int PRE   = 3;
  localparam int EDGES = 2 * W;
  localparam int WCYC  = EDGES * DIV;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpol = 1'b0;
  logic         cpha = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_wr = 1'b0;
  logic         miso = 1'b0;
  logic         tx_req, rx_valid, busy, sck, mosi, ss_n;
  logic [W-1:0] rx_data;

  spi_ce_master #(.WORD_W(W), .CLK_DIV(DIV), .PREFETCH(PRE)) i_spi_ce_master (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .tx_data(tx_data),
    .tx_wr(tx_wr), .tx_req(tx_req), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso)
  );

  always #2.5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  int    wd_cnt = 0;
  string ss_tag = "R11";
  string mosi_tag = "R5";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // pseudo-random miso, changed away from the active edge
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[15];
  end

  // behavioural reference, advanced on every active edge
  bit           mvalid = 0;
  int           mrun, mcyc, medge, mbit, mpend;
  logic [W-1:0] mword, mpdata, mrx, mrxd;
  logic         msck, mss, mrxv, mcont;

  always @(posedge clk) begin
    mvalid = 1;
    mrxv   = 0;
    mcont  = 0;
    if (!rst_n) begin
      mrun = 0; mcyc = 0; medge = 0; mpend = 0; mbit = 0;
      msck = cpol; mss = 1;
    end else if (mrun == 0) begin
      msck = cpol;
      if (tx_wr) begin
        mrun = 1; mss = 0; mword = tx_data; mbit = 0; mcyc = 0; medge = 0;
      end
    end else begin
      if (mcyc == DIV - 1) begin
        msck = ~msck;
        if ((medge % 2) == int'(cpha)) begin
          mrx = {mrx[W-2:0], miso};
          if (medge == (cpha ? EDGES - 1 : EDGES - 2)) begin
            mrxv = 1;
            mrxd = mrx;
          end
        end else if (medge != 0 && medge != EDGES - 1) begin
          mbit++;
        end
        if (medge == EDGES - 1) begin
          if (tx_wr || mpend != 0) begin
            mword = tx_wr ? tx_data : mpdata;
            mbit = 0; mpend = 0; mcont = 1;
          end else begin
            mrun = 0; mss = 1;
          end
          medge = 0;
        end else begin
          medge++;
        end
        mcyc = 0;
      end else begin
        mcyc++;
      end
      if (tx_wr && !mcont && mrun != 0) begin
        mpend = 1;
        mpdata = tx_data;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (mvalid) begin
      chk((mrun != 0) ? "R4" : "R2", sck, msck);
      chk(ss_tag, ss_n, mss);
      chk("R3", busy, mrun != 0);
      if (mrun != 0) chk(mosi_tag, mosi, mword[W-1-mbit]);
      chk("R8", tx_req, (mrun != 0) && ((medge * DIV + mcyc) == WCYC - PRE));
      chk("R7", rx_valid, mrxv);
      if (mrxv) chk("R6", rx_data, mrxd);
    end
  end

  task automatic put_word(input logic [W-1:0] d);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_req();
    @(negedge clk);
    while (!tx_req) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 60000) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", ss_n, 1'b1);
    chk("R1", sck, cpol);
    chk("R1", busy, 1'b0);
    chk("R1", tx_req, 1'b0);
    chk("R1", rx_valid, 1'b0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      cpol = m[1];
      cpha = m[0];
      repeat (3) @(negedge clk);
      chk("R2", sck, cpol);

      // R3: single word start
      put_word(8'hA5 ^ 8'(m));
      chk("R3", ss_n, 1'b0);
      chk("R3", mosi, (8'hA5 ^ 8'(m)) >> 7);
      wait_idle();
      repeat (2) @(negedge clk);

      // R9: back-to-back words driven by the request
      ss_tag = "R9";
      put_word(8'h3C + 8'(m));
      for (int k = 0; k < 2; k++) begin
        wait_req();
        put_word(8'hC3 - 8'(k * 17 + m));
      end
      wait_idle();
      ss_tag = "R11";
      repeat (2) @(negedge clk);

      // R10: waiting word overwritten twice
      mosi_tag = "R10";
      put_word(8'h81);
      repeat (4) @(negedge clk);
      put_word(8'h5A);
      repeat (3) @(negedge clk);
      put_word(8'hE7 ^ 8'(m));
      wait_idle();
      mosi_tag = "R5";

      // R11: write too late, select must rise in between
      put_word(8'h0F);
      wait_idle();
      put_word(8'hF0);
      wait_idle();
      repeat (3) @(negedge clk);
    end

    // R12: reset in the middle of a word
    put_word(8'h96);
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12", ss_n, 1'b1);
    chk("R12", busy, 1'b0);
    chk("R12", sck, cpol);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    put_word(8'h69);
    wait_idle();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule